// File: doc/BRIEF.md
# Indirect Memory Window Register Bank

This block is a small group of host registers through which a controller reaches two memories it cannot address directly. The first is a large buffer memory with 16-bit words and a 16-bit address. The second is a 256-word side RAM with 12-bit words, used by an embedded processor. The host first loads a high address byte, then a low address byte into the write-address or read-address register. After that it moves words through a single data register. An internal pointer steps by one after every buffer transfer, so block moves need no further address writes.

Each buffer access takes a fixed, parameterised number of cycles. While an access runs, a busy flag is set; it appears both in the status register and on a dedicated pin, and the host must wait for it to clear. Setting the side-select bit (bit 10) in an address write sends the access to the side RAM instead. A side write stores the 12-bit high-address register. A side read splits the word: the low byte goes to the data register, and the top nibble goes to a status field in mirrored order.

A chip-select register gates a set of auxiliary control registers. The memory window responds whatever the chip-select holds.

Top module: `mem_window_bank`

## Requirements
- R1: After reset the status register (9), data register (8), pointer readback (10) and chip-select (198) all read 0, and `busyOut` is low.
- R2: A write to register 8, made while register 6 was last loaded with bit 10 clear, starts a buffer write. `bufReq` and `bufWe` are held high for exactly `ACCESS_CYCLES` cycles (default 4). `bufAddr` is {register 5 bits 7:0, register 6 bits 7:0} and `bufWdata` is the written word.
- R3: Each completed buffer access adds one to the 16-bit pointer, which reads back from register 10. The pointer wraps from 0xFFFF to 0x0000.
- R4: A write to register 7 with bit 10 clear loads the pointer and starts a buffer read. When busy clears, register 8 holds `bufRdata` for that address. A read strobe on register 8 while idle starts the read of the next address.
- R5: `busyOut` equals status bit 0 at every cycle. It is high from the cycle after an access is issued until that access completes.
- R6: A write to register 8 while busy is ignored: it causes no buffer access and does not change the data. It sets status bit 1, which stays set until reset.
- R7: A write to register 6 with bit 10 set pulses `sideWe` for one cycle. `sideAddr` is data bits 7:0 and `sideWdata` is the 12-bit content of register 5. The pointer is unchanged and no buffer access occurs.
- R8: A write to register 7 with bit 10 set reads side word w at data bits 7:0. Register 8 then reads {8'h00, w[7:0]}, and status bit 8+k equals w[11-k] for k = 0..3.
- R9: Register 198 bit 0 is the chip-select. Auxiliary registers 194..197 accept writes and read back only while it is 1. While it is 0, writes to them are ignored and they read 0. Registers 5..10 and 198 respond regardless.
- R10: Unused bits read 0 (register 5 bits 15:12, status bits 7:2 and 15:12). Registers 6 and 7 and unassigned numbers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (advances a buffer read on register 8) |
| regAddr | input | 8 | Register number |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational from regAddr |
| bufReq | output | 1 | Buffer access active |
| bufWe | output | 1 | Buffer access is a write |
| bufAddr | output | 16 | Buffer word address |
| bufWdata | output | 16 | Buffer write data |
| bufRdata | input | 16 | Buffer read data, valid while bufReq is high |
| sideWe | output | 1 | Side RAM write strobe |
| sideAddr | output | 8 | Side RAM address |
| sideWdata | output | 12 | Side RAM write data |
| sideRdata | input | 12 | Side RAM read data, combinational from sideAddr |
| busyOut | output | 1 | Busy flag pin |

## Verification
Buffer writes are tried both as a single word and as back-to-back words. This tells a fresh pointer load apart from auto-increment. An address of 0xFFFF shows whether the pointer wraps or carries into a wider register. Buffer reads are checked for both the first fetch and a strobe-driven second fetch, which shows whether the read strobe rather than the address write moves the pointer. A data write made during busy tells a dropped write apart from one that was queued or that overwrote the data. Two side words with different top nibbles (0xA and 0x3) tell a mirrored nibble apart from a copied one. The auxiliary registers are written and read with chip-select off, on, and off again, which separates gating from loss of the stored value.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  localparam int REG_W      = 16;
  localparam int SIDE_W     = 12;
  localparam int RADDR_W    = 8;
  localparam int REG_HI     = 5;
  localparam int REG_WADDR  = 6;
  localparam int REG_RADDR  = 7;
  localparam int REG_DATA   = 8;
  localparam int REG_STAT   = 9;
  localparam int REG_PTR    = 10;
  localparam int REG_CS     = 198;
  localparam int SIDE_BIT   = 10;

  typedef enum logic [1:0] {MODE_NONE, MODE_WR, MODE_RD} winModeT;

  typedef struct packed {
    logic ldHi;
    logic ldPtr;
    logic ldData;
    logic capBuf;
    logic capSide;
    logic incPtr;
    logic setOvf;
    logic ldCs;
    logic ldAux;
  } winStrobeT;
endpackage

// File: rtl/mwb_ctrl.sv
module mwb_ctrl
  import mwb_pkg::*;
#(
  parameter int ACCESS_CYCLES = 4,
  parameter int AUX_BASE      = 194,
  parameter int NUM_AUX       = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic               sideSel,
  input  logic               csEn,
  output winStrobeT          stb,
  output logic               busy,
  output logic               opWrite,
  output logic               sideWe
);
  localparam int CNT_W = (ACCESS_CYCLES > 1) ? $clog2(ACCESS_CYCLES) : 1;

  logic [CNT_W-1:0] cnt;
  winModeT mode;
  logic hitHi, hitWa, hitRa, hitData, hitCs, hitAux;
  logic wrIdle, startWr, startRd, done;

  assign hitHi   = regAddr == RADDR_W'(REG_HI);
  assign hitWa   = regAddr == RADDR_W'(REG_WADDR);
  assign hitRa   = regAddr == RADDR_W'(REG_RADDR);
  assign hitData = regAddr == RADDR_W'(REG_DATA);
  assign hitCs   = regAddr == RADDR_W'(REG_CS);
  assign hitAux  = (int'(regAddr) >= AUX_BASE) && (int'(regAddr) < AUX_BASE + NUM_AUX);

  assign wrIdle  = regWr && !busy;
  assign startWr = wrIdle && hitData && (mode == MODE_WR);
  assign startRd = (wrIdle && hitRa && !sideSel) ||
                   (regRd && !regWr && !busy && hitData && (mode == MODE_RD));
  assign done    = busy && (cnt == '0);
  assign sideWe  = wrIdle && hitWa && sideSel;

  always_comb begin
    stb         = '0;
    stb.ldHi    = regWr && hitHi;
    stb.ldPtr   = wrIdle && (hitWa || hitRa) && !sideSel;
    stb.ldData  = startWr;
    stb.capSide = wrIdle && hitRa && sideSel;
    stb.incPtr  = done;
    stb.capBuf  = done && !opWrite;
    stb.setOvf  = regWr && busy && hitData;
    stb.ldCs    = regWr && hitCs;
    stb.ldAux   = regWr && hitAux && csEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      opWrite <= 1'b0;
      mode    <= MODE_NONE;
    end else begin
      if (stb.ldPtr) mode <= hitWa ? MODE_WR : MODE_RD;
      if (startWr || startRd) begin
        busy    <= 1'b1;
        cnt     <= CNT_W'(ACCESS_CYCLES - 1);
        opWrite <= startWr;
      end else if (done) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mwb_datapath.sv
module mwb_datapath
  import mwb_pkg::*;
#(
  parameter int AUX_BASE = 194,
  parameter int NUM_AUX  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  winStrobeT          stb,
  input  logic               busy,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]   regWdata,
  input  logic [REG_W-1:0]   bufRdata,
  input  logic [SIDE_W-1:0]  sideRdata,
  output logic [REG_W-1:0]   regRdata,
  output logic [SIDE_W-1:0]  hiReg,
  output logic [REG_W-1:0]   ptr,
  output logic [REG_W-1:0]   dataReg,
  output logic               csEn,
  output logic               ovf
);
  localparam int EXT_W = SIDE_W - 8;

  logic [EXT_W-1:0] ext, extNext;
  logic [REG_W-1:0] aux [NUM_AUX];

  always_comb begin
    for (int k = 0; k < EXT_W; k++) extNext[k] = sideRdata[SIDE_W-1-k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg   <= '0;
      ptr     <= '0;
      dataReg <= '0;
      ext     <= '0;
      csEn    <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (stb.ldHi)   hiReg <= regWdata[SIDE_W-1:0];
      if (stb.ldPtr)  ptr   <= {hiReg[7:0], regWdata[7:0]};
      else if (stb.incPtr) ptr <= ptr + 1'b1;
      if (stb.ldData) dataReg <= regWdata;
      else if (stb.capBuf) dataReg <= bufRdata;
      else if (stb.capSide) begin
        dataReg <= {8'h00, sideRdata[7:0]};
        ext     <= extNext;
      end
      if (stb.setOvf) ovf  <= 1'b1;
      if (stb.ldCs)   csEn <= regWdata[0];
    end
  end

  for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
    always_ff @(posedge clk) begin
      if (!rstN) aux[i] <= '0;
      else if (stb.ldAux && (int'(regAddr) == AUX_BASE + i)) aux[i] <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    case (int'(regAddr))
      REG_HI:   regRdata = {{(REG_W-SIDE_W){1'b0}}, hiReg};
      REG_DATA: regRdata = dataReg;
      REG_STAT: regRdata = {{(REG_W-8-EXT_W){1'b0}}, ext, 6'b0, ovf, busy};
      REG_PTR:  regRdata = ptr;
      REG_CS:   regRdata = {{(REG_W-1){1'b0}}, csEn};
      default: begin
        for (int i = 0; i < NUM_AUX; i++)
          if (csEn && (int'(regAddr) == AUX_BASE + i)) regRdata = aux[i];
      end
    endcase
  end
endmodule

// File: rtl/mem_window_bank.sv
module mem_window_bank
  import mwb_pkg::*;
#(
  parameter int ACCESS_CYCLES = 4,
  parameter int AUX_BASE      = 194,
  parameter int NUM_AUX       = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [7:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  output logic        bufReq,
  output logic        bufWe,
  output logic [15:0] bufAddr,
  output logic [15:0] bufWdata,
  input  logic [15:0] bufRdata,
  output logic        sideWe,
  output logic [7:0]  sideAddr,
  output logic [11:0] sideWdata,
  input  logic [11:0] sideRdata,
  output logic        busyOut
);
  winStrobeT stb;
  logic busy, opWrite, csEn, ovfQ;
  logic [SIDE_W-1:0] hiReg;
  logic [REG_W-1:0] ptrQ, dataReg;

  mwb_ctrl #(.ACCESS_CYCLES(ACCESS_CYCLES), .AUX_BASE(AUX_BASE), .NUM_AUX(NUM_AUX)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .sideSel(regWdata[SIDE_BIT]), .csEn(csEn), .stb(stb), .busy(busy),
    .opWrite(opWrite), .sideWe(sideWe)
  );

  mwb_datapath #(.AUX_BASE(AUX_BASE), .NUM_AUX(NUM_AUX)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .regAddr(regAddr),
    .regWdata(regWdata), .bufRdata(bufRdata), .sideRdata(sideRdata),
    .regRdata(regRdata), .hiReg(hiReg), .ptr(ptrQ), .dataReg(dataReg),
    .csEn(csEn), .ovf(ovfQ)
  );

  assign bufReq    = busy;
  assign bufWe     = busy && opWrite;
  assign bufAddr   = ptrQ;
  assign bufWdata  = dataReg;
  assign sideAddr  = regWdata[7:0];
  assign sideWdata = hiReg;
  assign busyOut   = busy;
endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
  parameter int ACCESS_CYCLES = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic [7:0]  regAddr,
  input logic [15:0] regRdata,
  input logic        busyOut,
  input logic        bufReq,
  input logic        sideWe,
  input logic [15:0] ptr,
  input logic        ovf
);
  int runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= 0;
    else if (busyOut) runLen <= runLen + 1;
    else runLen <= 0;
  end

  AST_BUSY_PIN_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 8'd9) |-> (regRdata[0] == busyOut)); // R5
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> (runLen == ACCESS_CYCLES)); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> (ptr == $past(ptr) + 16'd1)); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && regWr && regAddr == 8'd8) |=> ovf); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> ovf); // R6
  AST_SIDE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    sideWe |-> !bufReq); // R7
endmodule

bind mem_window_bank mwb_checker #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regRdata(regRdata),
  .busyOut(busyOut), .bufReq(bufReq), .sideWe(sideWe), .ptr(ptrQ), .ovf(ovfQ)
);

// File: tb/test_mem_window_bank.sv
module test_mem_window_bank;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata, bufAddr, bufWdata, bufRdata;
  logic bufReq, bufWe, sideWe, busyOut;
  logic [7:0] sideAddr;
  logic [11:0] sideWdata, sideRdata;

  logic [11:0] sideMem [256];
  int wrCycles = 0;
  logic [15:0] lastWrAddr = '0, lastWrData = '0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mem_window_bank i_mem_window_bank (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .bufReq(bufReq), .bufWe(bufWe),
    .bufAddr(bufAddr), .bufWdata(bufWdata), .bufRdata(bufRdata), .sideWe(sideWe),
    .sideAddr(sideAddr), .sideWdata(sideWdata), .sideRdata(sideRdata), .busyOut(busyOut)
  );

  assign bufRdata  = bufAddr ^ 16'hA5C3;
  assign sideRdata = sideMem[sideAddr];

  always @(posedge clk) begin
    if (bufReq && bufWe) begin
      wrCycles   <= wrCycles + 1;
      lastWrAddr <= bufAddr;
      lastWrData <= bufWdata;
    end
    if (sideWe) sideMem[sideAddr] <= sideWdata;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input int a, input int d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 8'(a); regWdata = 16'(d);
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic regPeek(input int a, output logic [15:0] v);
    regAddr = 8'(a);
    #1 v = regRdata;
  endtask

  task automatic regPop();
    @(negedge clk);
    regRd = 1'b1; regAddr = 8'd8;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    logic [15:0] st;
    n = 0;
    while (busyOut && n < 100) begin
      regPeek(9, st);
      check(st[0] == busyOut, "R5 status bit0 vs pin", st[0], busyOut);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    logic [15:0] v;
    regPeek(9, v);   check(v == 0, "R1 status", v, 0);
    regPeek(8, v);   check(v == 0, "R1 data", v, 0);
    regPeek(10, v);  check(v == 0, "R1 pointer", v, 0);
    regPeek(198, v); check(v == 0, "R1 chip-select", v, 0);
    check(busyOut == 0, "R1 busy pin", busyOut, 0);
  endtask

  task automatic testBufWrite();
    int n, w0;
    logic [15:0] v;
    regWrite(5, 16'h0040);
    regWrite(6, 16'h0010);
    w0 = wrCycles;
    regWrite(8, 16'hBEEF);
    check(busyOut == 1, "R5 busy after issue", busyOut, 1);
    waitIdle(n);
    check(n == LAT, "R2 busy length", n, LAT);
    check(wrCycles - w0 == LAT, "R2 write cycles", wrCycles - w0, LAT);
    check(lastWrAddr == 16'h4010, "R2 write address", lastWrAddr, 16'h4010);
    check(lastWrData == 16'hBEEF, "R2 write data", lastWrData, 16'hBEEF);
    regPeek(10, v); check(v == 16'h4011, "R3 pointer step", v, 16'h4011);
    regWrite(8, 16'h1111);
    waitIdle(n);
    check(lastWrAddr == 16'h4011, "R3 second write address", lastWrAddr, 16'h4011);
    regPeek(10, v); check(v == 16'h4012, "R3 pointer second step", v, 16'h4012);
  endtask

  task automatic testOverflow();
    int n, w0;
    logic [15:0] v;
    regPeek(9, v); check(v[1] == 0, "R6 overflow clear before", v[1], 0);
    w0 = wrCycles;
    regWrite(8, 16'h2222);
    regWrite(8, 16'h3333);
    waitIdle(n);
    check(wrCycles - w0 == LAT, "R6 no extra access", wrCycles - w0, LAT);
    check(lastWrData == 16'h2222, "R6 busy write dropped", lastWrData, 16'h2222);
    regPeek(8, v); check(v == 16'h2222, "R6 data unchanged", v, 16'h2222);
    regPeek(9, v); check(v[1] == 1, "R6 overflow set", v[1], 1);
    repeat (3) @(negedge clk);
    regPeek(9, v); check(v[1] == 1, "R6 overflow sticky", v[1], 1);
  endtask

  task automatic testWrap();
    int n;
    logic [15:0] v;
    regWrite(5, 16'h00FF);
    regWrite(6, 16'h00FF);
    regWrite(8, 16'h5A5A);
    waitIdle(n);
    check(lastWrAddr == 16'hFFFF, "R2 top address", lastWrAddr, 16'hFFFF);
    regPeek(10, v); check(v == 16'h0000, "R3 pointer wrap", v, 0);
  endtask

  task automatic testBufRead();
    int n;
    logic [15:0] v;
    regWrite(5, 16'h0012);
    regWrite(7, 16'h0034);
    check(busyOut == 1, "R4 read busy", busyOut, 1);
    waitIdle(n);
    check(n == LAT, "R4 read busy length", n, LAT);
    regPeek(8, v); check(v == (16'h1234 ^ 16'hA5C3), "R4 first read", v, 16'h1234 ^ 16'hA5C3);
    regPeek(10, v); check(v == 16'h1235, "R3 read pointer step", v, 16'h1235);
    regPop();
    waitIdle(n);
    regPeek(8, v); check(v == (16'h1235 ^ 16'hA5C3), "R4 next read", v, 16'h1235 ^ 16'hA5C3);
    regPeek(10, v); check(v == 16'h1236, "R3 pointer after pop", v, 16'h1236);
  endtask

  task automatic testSide();
    logic [15:0] v, p0;
    int w0;
    regPeek(10, p0);
    w0 = wrCycles;
    regWrite(5, 16'h0ABC);
    regWrite(6, 16'h0412);
    check(sideMem[8'h12] == 12'hABC, "R7 side write", sideMem[8'h12], 12'hABC);
    check(busyOut == 0, "R7 no busy", busyOut, 0);
    check(wrCycles == w0, "R7 no buffer access", wrCycles - w0, 0);
    regPeek(10, v); check(v == p0, "R7 pointer kept", v, p0);
    regWrite(5, 16'h03C5);
    regWrite(6, 16'h0420);
    regWrite(7, 16'h0412);
    regPeek(8, v); check(v == 16'h00BC, "R8 low byte", v, 16'h00BC);
    regPeek(9, v); check(v[11:8] == 4'h5, "R8 reversed nibble A", v[11:8], 4'h5);
    regWrite(7, 16'h0420);
    regPeek(8, v); check(v == 16'h00C5, "R8 low byte 2", v, 16'h00C5);
    regPeek(9, v); check(v[11:8] == 4'hC, "R8 reversed nibble 3", v[11:8], 4'hC);
    check(v[15:12] == 0 && v[7:2] == 0, "R10 status unused bits", v, v & 16'h0F03);
  endtask

  task automatic testChipSelect();
    logic [15:0] v;
    regWrite(194, 16'h1234);
    regPeek(194, v); check(v == 0, "R9 aux closed", v, 0);
    regWrite(198, 1);
    regPeek(194, v); check(v == 0, "R9 closed write ignored", v, 0);
    regWrite(197, 16'hCAFE);
    regPeek(197, v); check(v == 16'hCAFE, "R9 aux open", v, 16'hCAFE);
    regWrite(198, 0);
    regPeek(197, v); check(v == 0, "R9 aux hidden", v, 0);
    regWrite(5, 16'hFFFF);
    regPeek(5, v); check(v == 16'h0FFF, "R9 R10 window live, high bits zero", v, 16'h0FFF);
    regWrite(198, 1);
    regPeek(197, v); check(v == 16'hCAFE, "R9 aux retained", v, 16'hCAFE);
    regPeek(6, v); check(v == 0, "R10 reg6 reads zero", v, 0);
    regPeek(3, v); check(v == 0, "R10 unassigned reads zero", v, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) sideMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBufWrite();
    testOverflow();
    testWrap();
    testBufRead();
    testSide();
    testChipSelect();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      summary();
      $finish;
    end
  end
endmodule